// File: doc/BRIEF.md
# Chien Search Root Finder with Corrected-Error Count

This block sits between the key-equation solver and the correction stage of a binary BCH decoder for satellite broadcast frames. It takes an error-locator polynomial of degree at most 12 and finds its roots over the codeword positions. It tests `LANES` positions per clock, where `LANES` is 1 or 8 to match the width of the data path. From the roots it emits a flip mask that lines up with the buffered codeword bits. The correction stage XORs this mask into the message bits. The field is GF(2^16) for long frames and GF(2^14) for short frames, and the choice is made per frame.

A frame starts with a one-cycle `locStart` pulse. That pulse loads the coefficients, the frame type, the correction capability `tMax` and the codeword and message lengths. The search then runs two sweeps:

- **Counting sweep.** It runs upward from polynomial degree 0 to `cwLen-1` and counts every root, parity positions included. It emits nothing.
- **Emitting sweep.** It runs downward through the message positions in transmit order and emits the mask, framed by start, end and valid.

A signed count of corrected bits comes out on the last mask beat. A frame that cannot be decoded reports -1 and an all-zero mask.

Top module: `chien_search`

## Requirements
- R1: After reset, `outValid`, `outStart` and `outEnd` are 0, `outMask` is 0, `errCount` is 0 and `ready` is 1.
- R2: The field is GF(2^16) with the primitive polynomial x^16+x^5+x^3+x^2+1 when `frameShort`=0, and GF(2^14) with x^14+x^5+x^3+x+1 when `frameShort`=1. Coefficient `locCoef[i]` multiplies x^i, coefficient 0 is 1, and in short mode only bits 13:0 are used.
- R3: Codeword bit t (t=0 is transmitted first) has polynomial degree `cwLen-1-t`. It is in error when the locator vanishes at alpha^-(cwLen-1-t). In mask beat b, `outMask[j]` is the flip flag of bit b*LANES+j.
- R4: The design emits exactly `msgLen/LANES` mask beats on consecutive cycles. The first beat is registered at the (`cwLen/LANES`+1)-th rising edge after the edge that sampled `locStart`. `outStart` marks the first beat and `outEnd` marks the last. `cwLen` and `msgLen` are nonzero multiples of `LANES`, with `msgLen` ≤ `cwLen` ≤ 2^m-1.
- R5: When the frame is decodable, `errCount` on the `outEnd` beat equals the number of roots among all `cwLen` positions, parity positions included. It stays there until the next `locStart`.
- R6: A locator equal to 1 (degree 0) gives an all-zero mask and `errCount` = 0.
- R7: If the distinct root count differs from the locator degree (the index of the highest nonzero coefficient), the frame fails. This covers a root outside the codeword and a repeated root. A failed frame gives an all-zero mask and `errCount` = -1 (5'b11111).
- R8: If the locator degree exceeds the `tMax` sampled at start, the frame fails with the R7 outcome. A degree equal to `tMax` decodes normally.
- R9: A `locStart` while a search is running abandons that search, emits nothing more for it, and starts the new frame with R4 timing.
- R10: `ready` drops on the cycle after `locStart` and rises when the last mask beat is registered. While `outValid` is 0, `outMask`, `outStart` and `outEnd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| locStart | input | 1 | One-cycle pulse that loads a new locator and frame setup |
| frameShort | input | 1 | 0 selects GF(2^16), 1 selects GF(2^14) |
| tMax | input | 4 | Correction capability of the current code rate |
| cwLen | input | LEN_W | Codeword length in bits |
| msgLen | input | LEN_W | Message length in bits |
| locCoef | input | (MAX_DEG+1)*16 | Locator coefficients; element i multiplies x^i |
| ready | output | 1 | High when no search is running |
| outValid | output | 1 | Mask beat valid |
| outStart | output | 1 | First mask beat of the frame |
| outEnd | output | 1 | Last mask beat of the frame |
| outMask | output | LANES | Flip flags; lane 0 is the earliest bit of the beat |
| errCount | output | 5 (signed) | Corrected bit count, or -1 on failure |

## Verification
All timing is counted from the rising edge that samples `locStart`, which is edge 0.

- Each mask beat b is due just after edge `cwLen/LANES`+1+b.
- The end-of-frame count arrives with the last beat.
- `ready` rises after edge `cwLen/LANES`+`msgLen/LANES`.

The reference model in the bench derives these cycle numbers from the lengths. It compares valid, start, end, mask, ready and the count at every falling edge after the start, so an output that is one cycle early or late fails as surely as a wrong value. For the aborted frame, the count restarts at the edge of the second pulse, and the first frame must produce nothing in between.

// File: rtl/chien_pkg.sv
package chien_pkg;

  localparam int FIELD_W = 16;
  localparam int SHORT_W = 14;
  localparam int COUNT_W = 5;
  localparam logic [FIELD_W-1:0] LONG_POLY_LO  = 16'h002D;
  localparam logic [FIELD_W-1:0] SHORT_POLY_LO = 16'h002B;
  localparam logic [FIELD_W-1:0] SHORT_MASK    = 16'h3FFF;

  typedef logic [FIELD_W-1:0] gfElem_t;

  typedef struct packed {
    logic load;
    logic stepFwd;
    logic stepBwd;
  } dpCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_EMIT  = 2'd2
  } chienState_t;

  function automatic gfElem_t gfTimesAlpha(input gfElem_t x, input logic isShort);
    gfElem_t y;
    logic    msb;
    msb = isShort ? x[SHORT_W-1] : x[FIELD_W-1];
    y   = x << 1;
    if (isShort) y = y & SHORT_MASK;
    if (msb) y = y ^ (isShort ? SHORT_POLY_LO : LONG_POLY_LO);
    return y;
  endfunction

  function automatic gfElem_t gfDivAlpha(input gfElem_t x, input logic isShort);
    gfElem_t y;
    if (x[0]) begin
      y = (x ^ (isShort ? SHORT_POLY_LO : LONG_POLY_LO)) >> 1;
      if (isShort) y[SHORT_W-1] = 1'b1;
      else         y[FIELD_W-1] = 1'b1;
    end else begin
      y = x >> 1;
    end
    return y;
  endfunction

  // Multiply by alpha^k (up) or alpha^-k (down); k is constant at every call site.
  function automatic gfElem_t gfShift(input gfElem_t x, input int k, input logic up,
                                      input logic isShort);
    gfElem_t y;
    y = x;
    for (int s = 0; s < k; s++) begin
      y = up ? gfTimesAlpha(y, isShort) : gfDivAlpha(y, isShort);
    end
    return y;
  endfunction

endpackage

// File: rtl/chien_dp.sv
module chien_dp
  import chien_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int MAX_DEG = 12,
  parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCmd_t                            cmd,
  input  logic                              frameShort,
  input  logic [MAX_DEG:0][FIELD_W-1:0]     locCoef,
  output logic [LANES-1:0]                  fwdHits,
  output logic [LANES-1:0]                  bwdHits,
  output logic [DEG_W-1:0]                  degree
);

  localparam int NTERM = MAX_DEG + 1;

  gfElem_t          termReg [NTERM];
  gfElem_t          advFwd  [NTERM];
  gfElem_t          advBwd  [NTERM];
  gfElem_t          coefIn  [NTERM];
  logic             shortReg;
  logic [DEG_W-1:0] degIn;

  // Masked coefficients and degree of the incoming locator
  always_comb begin
    degIn = '0;
    for (int i = 0; i < NTERM; i++) begin
      coefIn[i] = frameShort ? (locCoef[i] & SHORT_MASK) : locCoef[i];
      if (i > 0 && coefIn[i] != '0) degIn = DEG_W'(i);
    end
  end

  // Per-term step: the whole beat of LANES positions at once
  for (genvar gi = 0; gi < NTERM; gi++) begin : gTerm
    assign advFwd[gi] = gfShift(termReg[gi], gi * LANES, 1'b0, shortReg);
    assign advBwd[gi] = gfShift(termReg[gi], gi * LANES, 1'b1, shortReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= '0;
      shortReg <= 1'b0;
      degree   <= '0;
    end else if (cmd.load) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= coefIn[i];
      shortReg <= frameShort;
      degree   <= degIn;
    end else if (cmd.stepFwd) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= advFwd[i];
    end else if (cmd.stepBwd) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= advBwd[i];
    end
  end

  // Lane evaluators: upward sweep lane j sits j degrees above the register point,
  // downward sweep lane j sits j+1 degrees below it.
  for (genvar gj = 0; gj < LANES; gj++) begin : gLane
    gfElem_t accF;
    gfElem_t accB;
    always_comb begin
      accF = '0;
      accB = '0;
      for (int i = 0; i < NTERM; i++) begin
        accF = accF ^ gfShift(termReg[i], i * gj, 1'b0, shortReg);
        accB = accB ^ gfShift(termReg[i], i * (gj + 1), 1'b1, shortReg);
      end
    end
    assign fwdHits[gj] = (accF == '0);
    assign bwdHits[gj] = (accB == '0);
  end

endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
  import chien_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 16,
  parameter int DEG_W = 4,
  parameter int T_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       locStart,
  input  logic [T_W-1:0]             tMax,
  input  logic [LEN_W-1:0]           cwLen,
  input  logic [LEN_W-1:0]           msgLen,
  input  logic [LANES-1:0]           fwdHits,
  input  logic [LANES-1:0]           bwdHits,
  input  logic [DEG_W-1:0]           degree,
  output dpCmd_t                     cmd,
  output logic                       ready,
  output logic                       outValid,
  output logic                       outStart,
  output logic                       outEnd,
  output logic [LANES-1:0]           outMask,
  output logic signed [COUNT_W-1:0]  errCount
);

  localparam int LANE_SH = $clog2(LANES);
  localparam int RC_W    = LEN_W + 1;

  chienState_t      state;
  logic [LEN_W-1:0] beatCnt;
  logic [LEN_W-1:0] countBeats;
  logic [LEN_W-1:0] emitBeats;
  logic [T_W-1:0]   tMaxReg;
  logic [RC_W-1:0]  rootCnt;
  logic [RC_W-1:0]  beatHitCnt;
  logic [RC_W-1:0]  rootTotal;
  logic             failReg;
  logic             lastCount;
  logic             lastEmit;
  logic             failNow;

  always_comb begin
    beatHitCnt = '0;
    for (int j = 0; j < LANES; j++) beatHitCnt = beatHitCnt + RC_W'(fwdHits[j]);
  end

  assign rootTotal = rootCnt + beatHitCnt;
  assign lastCount = (beatCnt == countBeats - LEN_W'(1));
  assign lastEmit  = (beatCnt == emitBeats - LEN_W'(1));
  assign failNow   = (rootTotal != RC_W'(degree)) || (int'(degree) > int'(tMaxReg));

  assign cmd.load    = locStart;
  assign cmd.stepFwd = !locStart && (state == ST_COUNT);
  assign cmd.stepBwd = !locStart && (state == ST_EMIT);
  assign ready       = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatCnt    <= '0;
      countBeats <= '0;
      emitBeats  <= '0;
      tMaxReg    <= '0;
      rootCnt    <= '0;
      failReg    <= 1'b0;
      outValid   <= 1'b0;
      outStart   <= 1'b0;
      outEnd     <= 1'b0;
      outMask    <= '0;
      errCount   <= '0;
    end else begin
      outValid <= 1'b0;
      outStart <= 1'b0;
      outEnd   <= 1'b0;
      outMask  <= '0;
      if (locStart) begin
        state      <= ST_COUNT;
        beatCnt    <= '0;
        rootCnt    <= '0;
        failReg    <= 1'b0;
        tMaxReg    <= tMax;
        countBeats <= cwLen >> LANE_SH;
        emitBeats  <= msgLen >> LANE_SH;
        errCount   <= '0;
      end else begin
        case (state)
          ST_COUNT: begin
            rootCnt <= rootTotal;
            if (lastCount) begin
              state   <= ST_EMIT;
              beatCnt <= '0;
              failReg <= failNow;
            end else begin
              beatCnt <= beatCnt + LEN_W'(1);
            end
          end
          ST_EMIT: begin
            outValid <= 1'b1;
            outMask  <= failReg ? '0 : bwdHits;
            outStart <= (beatCnt == '0);
            outEnd   <= lastEmit;
            if (lastEmit) begin
              errCount <= failReg ? '1 : COUNT_W'(degree);
              state    <= ST_IDLE;
            end else begin
              beatCnt <= beatCnt + LEN_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/chien_search.sv
module chien_search
  import chien_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int MAX_DEG = 12,
  parameter int LEN_W   = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           locStart,
  input  logic                           frameShort,
  input  logic [3:0]                     tMax,
  input  logic [LEN_W-1:0]               cwLen,
  input  logic [LEN_W-1:0]               msgLen,
  input  logic [MAX_DEG:0][FIELD_W-1:0]  locCoef,
  output logic                           ready,
  output logic                           outValid,
  output logic                           outStart,
  output logic                           outEnd,
  output logic [LANES-1:0]               outMask,
  output logic signed [COUNT_W-1:0]      errCount
);

  localparam int DEG_W = $clog2(MAX_DEG + 1);

  dpCmd_t           cmd;
  logic [LANES-1:0] fwdHits;
  logic [LANES-1:0] bwdHits;
  logic [DEG_W-1:0] degree;

  chien_dp #(
    .LANES  (LANES),
    .MAX_DEG(MAX_DEG),
    .DEG_W  (DEG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .frameShort(frameShort),
    .locCoef   (locCoef),
    .fwdHits   (fwdHits),
    .bwdHits   (bwdHits),
    .degree    (degree)
  );

  chien_ctrl #(
    .LANES(LANES),
    .LEN_W(LEN_W),
    .DEG_W(DEG_W),
    .T_W  (4)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .locStart  (locStart),
    .tMax      (tMax),
    .cwLen     (cwLen),
    .msgLen    (msgLen),
    .fwdHits   (fwdHits),
    .bwdHits   (bwdHits),
    .degree    (degree),
    .cmd       (cmd),
    .ready     (ready),
    .outValid  (outValid),
    .outStart  (outStart),
    .outEnd    (outEnd),
    .outMask   (outMask),
    .errCount  (errCount)
  );

endmodule

// File: rtl/chien_search_chk.sv
module chien_search_chk
  import chien_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int MAX_DEG = 12
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          locStart,
  input logic                          ready,
  input logic                          outValid,
  input logic                          outStart,
  input logic                          outEnd,
  input logic [LANES-1:0]              outMask,
  input logic signed [COUNT_W-1:0]     errCount
);

  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid); // R10
  AST_END_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> outValid); // R10
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outMask == '0)); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    locStart |=> !ready); // R10
  AST_FAIL_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outEnd && errCount == -5'sd1) |-> (outMask == '0)); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> (errCount == -5'sd1 || (errCount >= 0 && int'(errCount) <= MAX_DEG))); // R5
  AST_VALID_ENDS_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outValid) && !$past(locStart)) |-> $past(outEnd)); // R4

endmodule

bind chien_search chien_search_chk #(
  .LANES  (LANES),
  .MAX_DEG(MAX_DEG)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .locStart(locStart),
  .ready   (ready),
  .outValid(outValid),
  .outStart(outStart),
  .outEnd  (outEnd),
  .outMask (outMask),
  .errCount(errCount)
);

// File: tb/sim_chien_search.sv
`timescale 1ns/1ps
module sim_chien_search;

  localparam int L = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              locStart = 1'b0;
  logic              frameShort = 1'b0;
  logic [3:0]        tMax = 4'd12;
  logic [15:0]       cwLen = 16'd64;
  logic [15:0]       msgLen = 16'd40;
  logic [12:0][15:0] locCoef = '0;
  logic              ready;
  logic              outValid;
  logic              outStart;
  logic              outEnd;
  logic [L-1:0]      outMask;
  logic signed [4:0] errCount;

  int checks = 0;
  int failures = 0;
  int cycleCnt = 0;
  int errList[$];

  chien_search u0 (
    .clk(clk), .rstN(rstN), .locStart(locStart), .frameShort(frameShort),
    .tMax(tMax), .cwLen(cwLen), .msgLen(msgLen), .locCoef(locCoef),
    .ready(ready), .outValid(outValid), .outStart(outStart), .outEnd(outEnd),
    .outMask(outMask), .errCount(errCount)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 50000) begin
      failures++;
      $display("FAIL R4 watchdog expired: actual=%0d cycles expected<=50000", cycleCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gfMul(input int a, input int b, input bit sh);
    int m, poly, r;
    m    = sh ? 14 : 16;
    poly = sh ? 'h402B : 'h1002D;
    r    = 0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if ((r >> m) & 1) r = r ^ poly;
      if ((b >> i) & 1) r = r ^ a;
    end
    return r;
  endfunction

  function automatic int alphaPow(input int e, input bit sh);
    int r = 1;
    for (int i = 0; i < e; i++) r = gfMul(r, 2, sh);
    return r;
  endfunction

  // Builds the locator from errList, pulses start, then compares every cycle.
  task automatic runFrame(input bit sh, input int n, input int msg, input int tm, input string tag);
    int lam[13];
    int deg, uniq, p1, p2, expCnt;
    bit fail, seen;
    for (int i = 0; i < 13; i++) lam[i] = 0;
    lam[0] = 1;
    foreach (errList[k]) begin
      int x;
      x = alphaPow(errList[k], sh);
      for (int i = 12; i >= 1; i--) lam[i] = lam[i] ^ gfMul(x, lam[i-1], sh);
    end
    deg  = errList.size();
    uniq = 0;
    foreach (errList[k]) begin
      seen = 0;
      for (int q = 0; q < k; q++) if (errList[q] == errList[k]) seen = 1;
      if (!seen && errList[k] < n) uniq++;
    end
    fail   = (uniq != deg) || (deg > tm);
    expCnt = fail ? -1 : deg;
    p1 = n / L;
    p2 = msg / L;
    frameShort = sh;
    tMax       = 4'(tm);
    cwLen      = 16'(n);
    msgLen     = 16'(msg);
    for (int i = 0; i < 13; i++) locCoef[i] = 16'(lam[i]);
    locStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    locStart = 1'b0;
    checkEq("R10", {tag, " ready after start"}, int'(ready), 0);
    for (int k = 1; k <= p1 + p2 + 1; k++) begin
      bit expV;
      @(posedge clk);
      @(negedge clk);
      expV = (k >= p1 + 1) && (k <= p1 + p2);
      checkEq("R4", {tag, " outValid"}, int'(outValid), int'(expV));
      checkEq("R10", {tag, " ready"}, int'(ready), int'(k >= p1 + p2));
      if (expV) begin
        int b;
        b = k - p1 - 1;
        checkEq("R4", {tag, " outStart"}, int'(outStart), int'(b == 0));
        checkEq("R4", {tag, " outEnd"}, int'(outEnd), int'(b == p2 - 1));
        for (int j = 0; j < L; j++) begin
          int d;
          bit expF;
          d = n - 1 - (b * L + j);
          expF = 0;
          foreach (errList[q]) if (errList[q] == d) expF = !fail;
          checkEq(fail ? "R7" : "R3", {tag, " mask bit"}, int'(outMask[j]), int'(expF));
        end
        if (b == p2 - 1)
          checkEq(fail ? "R7" : "R5", {tag, " errCount"}, int'(errCount), expCnt);
      end else begin
        checkEq("R10", {tag, " idle mask"}, int'(outMask), 0);
      end
    end
    checkEq("R5", {tag, " count held"}, int'(errCount), expCnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "outValid", int'(outValid), 0);
    checkEq("R1", "ready", int'(ready), 1);
    checkEq("R1", "errCount", int'(errCount), 0);
    checkEq("R1", "outMask", int'(outMask), 0);

    // R3 R5: long field, first and lane-7 bits, last message bit, one parity root
    errList = '{63, 56, 24, 5};
    runFrame(1'b0, 64, 40, 12, "long4");

    // R2 R5 R8: short field, twelve errors with tMax = 12
    errList = '{47, 46, 40, 39, 33, 30, 25, 20, 17, 16, 9, 0};
    runFrame(1'b1, 48, 32, 12, "short12");

    // R6: error-free locator
    errList = {};
    runFrame(1'b0, 64, 40, 12, "clean");

    // R8: degree above tMax fails, degree equal to tMax decodes
    errList = '{60, 50, 40, 30, 20};
    runFrame(1'b0, 64, 40, 4, "overT");
    errList = '{60, 50, 40, 30};
    runFrame(1'b0, 64, 40, 4, "atT");

    // R7: root outside the codeword, and a repeated root
    errList = '{70, 45};
    runFrame(1'b0, 64, 40, 12, "outside");
    errList = '{50, 50};
    runFrame(1'b0, 64, 40, 12, "double");

    // R9: restart during the counting sweep
    errList = '{63, 56, 24, 5};
    cwLen = 16'd64; msgLen = 16'd40; frameShort = 1'b0; tMax = 4'd12;
    locStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    locStart = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      checkEq("R9", "aborted frame silent", int'(outValid), 0);
    end
    errList = '{35, 10};
    runFrame(1'b1, 48, 32, 12, "restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule